// File: doc/BRIEF.md
# Compare-Driven Waveform Timer Channel

This block is a single timer channel that generates two digital waveforms. A counter advances once per cycle in which the count strobe is high and the channel clock is running. Three compare registers (A, B and C) are checked against the counter on every counted tick. The channel has two outputs. Each output reacts to four events: its own compare register, compare C, an external edge, and a software trigger. For each pairing of output and event, a 2-bit action code chooses to hold, set, clear or toggle the output.

The counting profile is chosen at run time. The counter can count up and wrap, count up and down across the full range, count up and restart at compare C, or count up to compare C and then back down. A compare C match can freeze the counter until the next trigger, or it can switch the channel clock off until software enables it again. An external edge can also restart the counter. Software drives the channel through a small word-addressed register port: command, mode, compare values, sticky status and an interrupt mask.

Top module: `tmr_wave_chan`

## Requirements
- R1: After reset, the counter reads 0 and the channel clock is off. Both outputs, the irq line, the status word and the interrupt mask are 0. Word addresses are: 0 command (write only), 1 mode, 2 counter (read only), 3 compare A, 4 compare B, 5 compare C, 6 status, 7 mask-set, 8 mask-clear, 9 mask readback.
- R2: A command write with bit 0 set turns the channel clock on, and bit 1 turns it off. When both bits are written together, the clock ends up off. While the clock is off, strobes do not advance the counter. Status bit 16 reads 1 only while the clock is on and the counter is not frozen.
- R3: Mode bits 14:13 select the profile. Code 0 counts up and wraps from full scale to 0. A counted tick that finds the counter at full scale while counting up sets status bit 0.
- R4: Profile code 1 counts up to full scale, then down to 0, then up again, without resting at either end.
- R5: Profile code 2 counts up. A counted tick that finds the counter equal to compare C loads 0.
- R6: Profile code 3 counts up until a tick finds the counter equal to compare C, then counts down. A tick that finds 0 while counting down moves the counter to 1 and turns the direction up.
- R7: A counted tick that finds the counter equal to compare A, B or C sets status bit 2, 3 or 4. It also applies the action codes (0 hold, 1 set, 2 clear, 3 toggle). Output A uses mode bits 17:16 for compare A, 19:18 for compare C, 21:20 for the external event and 23:22 for the software trigger. Output B uses bits 25:24 for compare B, 27:26 for compare C, 29:28 for the external event and 31:30 for the software trigger. The new level appears after the clock edge.
- R8: When events with non-hold actions reach one output in the same cycle, the software trigger wins. The external event comes next, then compare C, then the output's own compare.
- R9: With mode bit 6 set, a compare C match freezes the counter until the next trigger. With mode bit 7 set, a compare C match turns the channel clock off until a command enables it.
- R10: Mode bits 9:8 select the external edge: 0 none, 1 rising, 2 falling, 3 both. Bits 11:10 select the source: 0 is the B pad input, and 1 to 3 are external lines 0 to 2. A detected edge sets status bit 7. With bit 12 set, the edge also restarts the counter. Edges on lines that are not selected have no effect.
- R11: A command write with bit 2 set is a software trigger. It loads the counter with 0, sets the direction up and releases a frozen counter.
- R12: Status bits 17 and 18 mirror outputs A and B. Event bits 0 to 7 are sticky and clear when the status word is read. An event that arrives in the same cycle as the read is kept.
- R13: Writing 1 bits to address 7 sets mask bits, and writing 1 bits to address 8 clears them. Address 9 returns the mask. irq is high whenever a sticky status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count strobe |
| ext_in | input | 3 | External event lines 0 to 2 |
| pin_b_in | input | 1 | Pad value of output B, usable as event source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address for write or read |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe (status read clears events) |
| rd_data | output | 32 | Read data, combinational, 0 when rd_en is low |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| irq | output | 1 | Masked interrupt request |

## Verification
The software trigger and the external edge can reach output A in the same cycle, and the outcome depends on the fixed ranking between them. The bench first drives a lone rising edge, which clears the output. It then raises the selected line in the same cycle as a trigger command while the trigger action is set. Output A must end high, since the edge alone would leave it low. A compare match can also coincide with a trigger; that case is judged by the counter reading 0 and by a toggle action flipping the output exactly once.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;

    localparam int DW = 32;
    localparam int AW = 4;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_FLIP = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        PRF_WRAP  = 2'd0,
        PRF_TRI   = 2'd1,
        PRF_RCUP  = 2'd2,
        PRF_RCTRI = 2'd3
    } prof_e;

    localparam logic [AW-1:0] A_CMD  = 4'd0;
    localparam logic [AW-1:0] A_MODE = 4'd1;
    localparam logic [AW-1:0] A_CNT  = 4'd2;
    localparam logic [AW-1:0] A_CA   = 4'd3;
    localparam logic [AW-1:0] A_CB   = 4'd4;
    localparam logic [AW-1:0] A_CC   = 4'd5;
    localparam logic [AW-1:0] A_STAT = 4'd6;
    localparam logic [AW-1:0] A_MSET = 4'd7;
    localparam logic [AW-1:0] A_MCLR = 4'd8;
    localparam logic [AW-1:0] A_MASK = 4'd9;

    // mode word fields
    localparam int M_FREEZE   = 6;
    localparam int M_HALT     = 7;
    localparam int M_EDGE_LO  = 8;
    localparam int M_SRC_LO   = 10;
    localparam int M_RESTART  = 12;
    localparam int M_PROF_LO  = 13;
    localparam int M_ACT_BASE = 16;
    localparam int M_ACT_SPAN = 8;

    // command bits
    localparam int C_ON   = 0;
    localparam int C_OFF  = 1;
    localparam int C_TRIG = 2;

endpackage

// File: rtl/tmr_wave_edge.sv
module tmr_wave_edge (
    input  logic       cur,
    input  logic       prev,
    input  logic [1:0] sel,
    output logic       hit
);
    always_comb begin
        case (sel)
            2'd1:    hit = cur & ~prev;
            2'd2:    hit = ~cur & prev;
            2'd3:    hit = cur ^ prev;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_wave_step.sv
module tmr_wave_step
    import tmr_wave_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic          up,
    input  logic [CW-1:0] lim,
    input  prof_e         prof,
    output logic [CW-1:0] nxt,
    output logic          nxt_up,
    output logic          ovf
);
    localparam logic [CW-1:0] FULL = '1;
    localparam logic [CW-1:0] ONE  = CW'(1);

    always_comb begin
        nxt    = cnt + ONE;
        nxt_up = 1'b1;
        ovf    = 1'b0;
        case (prof)
            PRF_WRAP: begin
                ovf = (cnt == FULL);
            end
            PRF_TRI: begin
                if (up) begin
                    if (cnt == FULL) begin
                        ovf    = 1'b1;
                        nxt    = cnt - ONE;
                        nxt_up = 1'b0;
                    end
                end else if (cnt == '0) begin
                    nxt = ONE;
                end else begin
                    nxt    = cnt - ONE;
                    nxt_up = 1'b0;
                end
            end
            PRF_RCUP: begin
                if (cnt == lim) begin
                    nxt = '0;
                end else if (cnt == FULL) begin
                    ovf = 1'b1;
                end
            end
            default: begin
                if (up) begin
                    if (cnt == lim) begin
                        nxt    = (cnt == '0) ? '0 : cnt - ONE;
                        nxt_up = 1'b0;
                    end else if (cnt == FULL) begin
                        ovf = 1'b1;
                    end
                end else if (cnt == '0) begin
                    nxt = ONE;
                end else begin
                    nxt    = cnt - ONE;
                    nxt_up = 1'b0;
                end
            end
        endcase
    end
endmodule

// File: rtl/tmr_wave_pin.sv
module tmr_wave_pin
    import tmr_wave_pkg::*;
(
    input  logic       cur,
    input  logic [3:0] hits,   // {sw, ext, cmp_c, own cmp}, highest first
    input  logic [7:0] acts,   // 2-bit code per event, same order as hits
    output logic       nxt
);
    always_comb begin
        nxt = cur;
        for (int i = 0; i < 4; i++) begin
            if (hits[i]) begin
                case (act_e'(acts[2*i +: 2]))
                    ACT_SET:  nxt = 1'b1;
                    ACT_CLR:  nxt = 1'b0;
                    ACT_FLIP: nxt = ~cur;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_wave_chan.sv
module tmr_wave_chan
    import tmr_wave_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_tick,
    input  logic [2:0]    ext_in,
    input  logic          pin_b_in,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          out_a,
    output logic          out_b,
    output logic          irq
);
    localparam int PINS = 2;

    typedef struct packed {
        logic [DW-1:0]   mode;
        logic [CW-1:0]   cnt;
        logic [CW-1:0]   cmp_a;
        logic [CW-1:0]   cmp_b;
        logic [CW-1:0]   cmp_c;
        logic            up;
        logic            run;
        logic            frozen;
        logic [7:0]      flags;
        logic [7:0]      mask;
        logic [PINS-1:0] pins;
        logic            src_prev;
    } state_t;

    state_t q, d;

    logic            src_now, ext_hit, sw_hit, trig, counting;
    logic            hit_a, hit_b, hit_c;
    logic            cmd_wr, rd_stat;
    logic [CW-1:0]   step_cnt;
    logic            step_up, step_ovf;
    logic [PINS-1:0] pin_nxt, cmp_hit;
    logic [7:0]      new_flags;
    logic [DW-1:0]   stat_word;

    // event source select
    always_comb begin
        case (q.mode[M_SRC_LO +: 2])
            2'd1:    src_now = ext_in[0];
            2'd2:    src_now = ext_in[1];
            2'd3:    src_now = ext_in[2];
            default: src_now = pin_b_in;
        endcase
    end

    tmr_wave_edge u_edge (
        .cur  (src_now),
        .prev (q.src_prev),
        .sel  (q.mode[M_EDGE_LO +: 2]),
        .hit  (ext_hit)
    );

    assign cmd_wr   = wr_en && (addr == A_CMD);
    assign rd_stat  = rd_en && (addr == A_STAT);
    assign sw_hit   = cmd_wr && wr_data[C_TRIG];
    assign trig     = sw_hit || (ext_hit && q.mode[M_RESTART]);
    assign counting = q.run && !q.frozen && cnt_tick;
    assign hit_a    = counting && (q.cnt == q.cmp_a);
    assign hit_b    = counting && (q.cnt == q.cmp_b);
    assign hit_c    = counting && (q.cnt == q.cmp_c);
    assign cmp_hit  = {hit_b, hit_a};

    tmr_wave_step #(.CW(CW)) u_step (
        .cnt    (q.cnt),
        .up     (q.up),
        .lim    (q.cmp_c),
        .prof   (prof_e'(q.mode[M_PROF_LO +: 2])),
        .nxt    (step_cnt),
        .nxt_up (step_up),
        .ovf    (step_ovf)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        tmr_wave_pin u_pin (
            .cur  (q.pins[p]),
            .hits ({sw_hit, ext_hit, hit_c, cmp_hit[p]}),
            .acts (q.mode[M_ACT_BASE + M_ACT_SPAN*p +: M_ACT_SPAN]),
            .nxt  (pin_nxt[p])
        );
    end

    assign new_flags = {ext_hit, 2'b00, hit_c, hit_b, hit_a, 1'b0, counting && step_ovf};

    always_comb begin
        d          = q;
        d.src_prev = src_now;
        d.pins     = pin_nxt;
        d.flags    = (rd_stat ? 8'h00 : q.flags) | new_flags;

        if (counting) begin
            d.cnt = step_cnt;
            d.up  = step_up;
        end
        if (hit_c && q.mode[M_FREEZE]) d.frozen = 1'b1;
        if (hit_c && q.mode[M_HALT])   d.run    = 1'b0;

        if (trig) begin
            d.cnt    = '0;
            d.up     = 1'b1;
            d.frozen = 1'b0;
        end

        if (cmd_wr && wr_data[C_ON])  d.run = 1'b1;
        if (cmd_wr && wr_data[C_OFF]) d.run = 1'b0;

        if (wr_en) begin
            case (addr)
                A_MODE: d.mode  = wr_data;
                A_CA:   d.cmp_a = wr_data[CW-1:0];
                A_CB:   d.cmp_b = wr_data[CW-1:0];
                A_CC:   d.cmp_c = wr_data[CW-1:0];
                A_MSET: d.mask  = q.mask | wr_data[7:0];
                A_MCLR: d.mask  = q.mask & ~wr_data[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.up <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign stat_word = {13'b0, q.pins[1], q.pins[0], q.run && !q.frozen, 8'b0, q.flags};

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (addr)
                A_MODE: rd_data = q.mode;
                A_CNT:  rd_data = DW'(q.cnt);
                A_CA:   rd_data = DW'(q.cmp_a);
                A_CB:   rd_data = DW'(q.cmp_b);
                A_CC:   rd_data = DW'(q.cmp_c);
                A_STAT: rd_data = stat_word;
                A_MASK: rd_data = DW'(q.mask);
                default: rd_data = '0;
            endcase
        end
    end

    assign out_a = q.pins[0];
    assign out_b = q.pins[1];
    assign irq   = |(q.flags & q.mask);

    // state brought out for the bound checker
    logic            chk_run, chk_frozen;
    logic [CW-1:0]   chk_cnt;
    logic [DW-1:0]   chk_mode;
    assign chk_run    = q.run;
    assign chk_frozen = q.frozen;
    assign chk_cnt    = q.cnt;
    assign chk_mode   = q.mode;

endmodule

// File: rtl/tmr_wave_chk.sv
module tmr_wave_chk
    import tmr_wave_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_tick,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wr_data,
    input logic          out_a,
    input logic          irq,
    input logic          run_q,
    input logic          frozen_q,
    input logic [CW-1:0] cnt_q,
    input logic [DW-1:0] mode_q
);
    localparam logic [CW-1:0] FULL = '1;

    logic cmd_wr;
    assign cmd_wr = wr_en && (addr == A_CMD);

    p_off_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wr_data[C_OFF] |=> !run_q);

    p_trig_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wr_data[C_TRIG] |=> cnt_q == '0);

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && !frozen_q && cnt_tick && mode_q[M_PROF_LO +: 2] == 2'd0 && cnt_q == FULL
        |=> cnt_q == '0);

    p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frozen_q && !(cmd_wr && wr_data[C_TRIG]) && !mode_q[M_RESTART] |=> $stable(cnt_q));

    p_sw_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wr_data[C_TRIG] && mode_q[M_ACT_BASE + 6 +: 2] == 2'd3
        |=> out_a != $past(out_a));

    p_mask_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_MCLR && wr_data[7:0] == 8'hFF |=> !irq);

endmodule

bind tmr_wave_chan tmr_wave_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_tick (cnt_tick),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .out_a    (out_a),
    .irq      (irq),
    .run_q    (chk_run),
    .frozen_q (chk_frozen),
    .cnt_q    (chk_cnt),
    .mode_q   (chk_mode)
);

// File: tb/tmr_wave_chan_bench.sv
module tmr_wave_chan_bench;

    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic [2:0]  ext_in = 3'b000;
    logic        pin_b_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wr_data = 32'd0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        out_a, out_b, irq;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    tmr_wave_chan #(.CW(CW)) u_tmr_wave_chan (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .ext_in(ext_in),
        .pin_b_in(pin_b_in), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .out_a(out_a), .out_b(out_b), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] mode;
        logic [7:0]  lim;
        logic [15:0] ticks;
        logic [7:0]  expv;
    } vec_t;

    localparam vec_t TBL [14] = '{
        '{32'h0000_0000, 8'd0,  16'd10,  8'd10},
        '{32'h0000_0000, 8'd0,  16'd256, 8'd0},
        '{32'h0000_0000, 8'd0,  16'd300, 8'd44},
        '{32'h0000_2000, 8'd0,  16'd255, 8'd255},
        '{32'h0000_2000, 8'd0,  16'd256, 8'd254},
        '{32'h0000_2000, 8'd0,  16'd510, 8'd0},
        '{32'h0000_2000, 8'd0,  16'd511, 8'd1},
        '{32'h0000_4000, 8'd20, 16'd20,  8'd20},
        '{32'h0000_4000, 8'd20, 16'd21,  8'd0},
        '{32'h0000_4000, 8'd20, 16'd25,  8'd4},
        '{32'h0000_6000, 8'd20, 16'd20,  8'd20},
        '{32'h0000_6000, 8'd20, 16'd21,  8'd19},
        '{32'h0000_6000, 8'd20, 16'd40,  8'd0},
        '{32'h0000_6000, 8'd20, 16'd41,  8'd1}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv);
        total++;
        if (got !== expv) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, expv);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        wr_en = 1'b1; addr = a; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = 32'd0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rd_data;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic tick(input int n);
        cnt_tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 cnt_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 190000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        string tag;
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(4'd2, v); check("R1 count", v, 32'd0);
        rd(4'd6, v); check("R1 status", v, 32'd0);
        rd(4'd9, v); check("R1 mask", v, 32'd0);
        check("R1 pins irq", {29'd0, out_a, out_b, irq}, 32'd0);

        // R2 command on/off, off wins
        wr(4'd0, 32'd3);
        rd(4'd6, v); check("R2 both->off", {31'd0, v[16]}, 32'd0);
        tick(3);
        rd(4'd2, v); check("R2 off holds count", v, 32'd0);
        wr(4'd0, 32'd1);
        rd(4'd6, v); check("R2 on", {31'd0, v[16]}, 32'd1);
        tick(3);
        rd(4'd2, v); check("R2 counts when on", v, 32'd3);
        wr(4'd0, 32'd2);
        rd(4'd6, v); check("R2 off", {31'd0, v[16]}, 32'd0);

        // profile table: R3 R4 R5 R6
        for (int i = 0; i < 14; i++) begin
            case (TBL[i].mode[14:13])
                2'd0: tag = "R3 profile wrap";
                2'd1: tag = "R4 profile up-down";
                2'd2: tag = "R5 profile restart";
                default: tag = "R6 profile up-to-C-down";
            endcase
            wr(4'd1, TBL[i].mode);
            wr(4'd5, {24'd0, TBL[i].lim});
            wr(4'd0, 32'd5);
            tick(int'(TBL[i].ticks));
            rd(4'd2, v);
            check($sformatf("%s row %0d", tag, i), v, {24'd0, TBL[i].expv});
        end

        // R3 overflow flag
        wr(4'd1, 32'd0);
        wr(4'd0, 32'd5);
        rd(4'd6, v);
        tick(255);
        rd(4'd6, v); check("R3 no overflow yet", {31'd0, v[0]}, 32'd0);
        tick(1);
        rd(4'd6, v); check("R3 overflow flag", {31'd0, v[0]}, 32'd1);

        // R7 compare actions, R13 mask, R12 status
        wr(4'd3, 32'd5);
        wr(4'd4, 32'd7);
        wr(4'd5, 32'd9);
        wr(4'd1, 32'h0309_0000);
        wr(4'd7, 32'h10);
        rd(4'd9, v); check("R13 mask readback", v, 32'h10);
        rd(4'd6, v);
        wr(4'd0, 32'd5);
        tick(6);
        check("R7 A set on compare A", {30'd0, out_a, out_b}, 32'b10);
        tick(2);
        check("R7 B toggle on compare B", {30'd0, out_a, out_b}, 32'b11);
        tick(2);
        check("R7 A clear on compare C", {30'd0, out_a, out_b}, 32'b01);
        check("R13 irq on masked C", {31'd0, irq}, 32'd1);
        wr(4'd8, 32'h10);
        check("R13 irq off after mask clear", {31'd0, irq}, 32'd0);
        rd(4'd9, v); check("R13 mask cleared", v, 32'd0);
        rd(4'd6, v); check("R12 status flags and mirrors", v & 32'h0006_00FF, 32'h0004_001C);
        rd(4'd6, v); check("R12 clear on read", v & 32'hFF, 32'd0);

        // R11 / R8 / R10: software trigger against external edge
        wr(4'd1, 32'h0060_0500);
        wr(4'd0, 32'd4);
        check("R11 sw trigger sets A", {31'd0, out_a}, 32'd1);
        rd(4'd2, v); check("R11 trigger zeroes count", v, 32'd0);
        ext_in[0] = 1'b1;
        idle(1);
        check("R10 rising edge clears A", {31'd0, out_a}, 32'd0);
        ext_in[0] = 1'b0;
        idle(1);
        rd(4'd6, v);
        ext_in[0] = 1'b1;
        wr(4'd0, 32'd4);
        check("R8 sw beats ext on A", {31'd0, out_a}, 32'd1);
        rd(4'd6, v); check("R10 event flag", {31'd0, v[7]}, 32'd1);
        ext_in[0] = 1'b0;
        idle(1);

        // R10 external restart on falling edge of line 1
        ext_in[1] = 1'b1;
        wr(4'd1, 32'h0000_1A00);
        idle(1);
        wr(4'd0, 32'd5);
        tick(5);
        rd(4'd2, v); check("R10 count before edge", v, 32'd5);
        ext_in[0] = 1'b1; idle(1);
        ext_in[0] = 1'b0; idle(1);
        rd(4'd2, v); check("R10 other line ignored", v, 32'd5);
        ext_in[1] = 1'b0; idle(1);
        rd(4'd2, v); check("R10 falling edge restarts", v, 32'd0);

        // R9 freeze on compare C
        wr(4'd5, 32'd3);
        wr(4'd1, 32'h40);
        wr(4'd0, 32'd5);
        tick(10);
        rd(4'd2, v); check("R9 freeze count", v, 32'd4);
        rd(4'd6, v); check("R9 frozen status", {31'd0, v[16]}, 32'd0);
        wr(4'd0, 32'd4);
        rd(4'd6, v); check("R9 trigger releases", {31'd0, v[16]}, 32'd1);

        // R9 halt on compare C
        wr(4'd1, 32'h80);
        wr(4'd0, 32'd5);
        tick(10);
        rd(4'd2, v); check("R9 halt count", v, 32'd4);
        wr(4'd0, 32'd4);
        tick(3);
        rd(4'd2, v); check("R9 trigger keeps halted", v, 32'd0);
        rd(4'd6, v); check("R9 still off", {31'd0, v[16]}, 32'd0);
        wr(4'd0, 32'd1);
        tick(2);
        rd(4'd2, v); check("R9 enable resumes", v, 32'd2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule